// File: doc/BRIEF.md
# Event-Triggered DMA Channel

This block is one channel of a data mover that copies bytes between memory-mapped locations each time a chosen hardware event line rises, with no processor service per event. Software programs a source base and size, a destination base and size, and a cell size. Each qualifying event moves one cell. The source and destination offsets each wrap back to zero at the end of their own regions. A one-register source can therefore fill a whole array, and a table can be replayed into a single peripheral register.

A block ends once the larger of the two region sizes has been moved. It can also end early when an optional pattern compare matches a moved value. At that point the channel raises a sticky done flag and a one-cycle interrupt pulse. It then either re-arms itself (repeat mode) or disarms (one-shot mode). An abort input stops the channel at any time. The memory master has separate read and write ports that share one ready signal, so a beat reads and writes in the same cycle. A separate combinational helper turns a virtual address into a physical one.

Top module: `evdma_channel`

## Requirements
- R1: A cell starts only on a rising edge of the event line whose index is `cfg_evt_sel`. Edges on the other lines are ignored.
- R2: Each served trigger moves exactly `cfg_cell_size` bytes. A beat is 2 bytes when `cfg_wide`=1 and 1 byte when it is 0. One beat completes in each cycle where `rd_req` and `mem_ready` are both high. While `mem_ready` is low, no beat completes and the addresses hold.
- R3: The source offset returns to 0 when it reaches `cfg_src_size`. The destination offset returns to 0 when it reaches `cfg_dst_size`. Each wraps independently of the other.
- R4: When max(`cfg_src_size`, `cfg_dst_size`) bytes have been moved, `done_flag` sets and `done_irq` pulses for one cycle.
- R5: With `cfg_match_en`=1, the block ends right after the beat whose moved value equals `cfg_pattern`. In 8-bit mode that value is the byte zero-extended. No later beat of that block is written.
- R6: In repeat mode (`cfg_auto`=1), the channel stays armed after a block, with both offsets back at 0. In one-shot mode it disarms, and later triggers move nothing.
- R7: A pulse on `abort_in` disarms the channel, clears its offsets and cell progress, sets `abort_flag` and pulses `abort_irq`. After a re-arm, the next cell starts at the two base addresses.
- R8: A trigger that arrives while a cell is in progress is held (one deep). It is served right after that cell, not lost.
- R9: In 8-bit mode, address bit 0 picks the byte lane: 0 is bits 7:0 and 1 is bits 15:8. The read byte is copied onto both write lanes, and `wr_be` enables only the destination lane (01 or 10). In 16-bit mode, `wr_be`=11 and the data passes unchanged.
- R10: `phys_addr` equals `virt_addr` AND 0x1FFF_FFFF.
- R11: `arm` given while disarmed clears both flags and arms the channel. `clear_flags` clears both flags.
- R12: After reset the channel is disarmed, both flags are low, and neither memory request is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm | input | 1 | Arm pulse, taken while disarmed |
| abort_in | input | 1 | Abort pulse |
| clear_flags | input | 1 | Clears the done and abort flags |
| cfg_auto | input | 1 | 1 = repeat mode, 0 = one-shot |
| cfg_wide | input | 1 | 1 = 16-bit beats, 0 = 8-bit beats |
| cfg_match_en | input | 1 | Enables the early stop on pattern match |
| cfg_pattern | input | 16 | Value that ends the block |
| cfg_evt_sel | input | SEL_W | Index of the trigger line |
| cfg_src_base | input | ADDR_W | Physical source base address |
| cfg_dst_base | input | ADDR_W | Physical destination base address |
| cfg_src_size | input | SIZE_W | Source region size in bytes |
| cfg_dst_size | input | SIZE_W | Destination region size in bytes |
| cfg_cell_size | input | SIZE_W | Bytes moved per trigger |
| evt_in | input | N_EVT | Hardware event lines |
| virt_addr | input | ADDR_W | Virtual address for conversion |
| phys_addr | output | ADDR_W | Converted physical address |
| rd_req | output | 1 | Read request |
| rd_addr | output | ADDR_W | Read byte address |
| rd_data | input | 16 | Read data, valid in the request cycle |
| wr_req | output | 1 | Write request |
| wr_addr | output | ADDR_W | Write byte address |
| wr_data | output | 16 | Write data |
| wr_be | output | 2 | Write byte enables |
| mem_ready | input | 1 | Memory accepts the current beat |
| armed | output | 1 | Channel is armed or moving |
| done_flag | output | 1 | Sticky block-complete flag |
| abort_flag | output | 1 | Sticky abort flag |
| done_irq | output | 1 | One-cycle completion pulse |
| abort_irq | output | 1 | One-cycle abort pulse |

## Verification
The bench builds the channel with its default parameters: four event lines, 16-bit size fields and 32-bit addresses. It programs region sizes of only 2 to 16 bytes, so a single test reaches source wrap, destination wrap, block end and repeat re-arm within a few events. Four event lines are enough to show that edges on unselected lines are ignored. The smallest regions, a 2-byte fixed source register and a 2-byte destination register, exercise a wrap on every beat. An odd destination base in 8-bit mode reaches both byte lanes within one block.

// File: rtl/evdma_pkg.sv
`timescale 1ns/1ps
package evdma_pkg;
    localparam int DATA_W = 16;
    localparam int BE_W   = DATA_W / 8;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_MOVE  = 2'd2
    } ch_state_e;
endpackage

// File: rtl/evdma_edge.sv
`timescale 1ns/1ps
module evdma_edge #(
    parameter int N_EVT = 4,
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_EVT-1:0] evt,
    input  logic [SEL_W-1:0] sel,
    output logic             rise
);
    logic [N_EVT-1:0] prev_d, prev_q;
    logic [N_EVT-1:0] rises;

    for (genvar i = 0; i < N_EVT; i++) begin : g_line
        assign rises[i] = evt[i] & ~prev_q[i];
    end

    always_comb begin
        prev_d = evt;
        rise   = 1'b0;
        for (int k = 0; k < N_EVT; k++) begin
            if (int'(sel) == k) rise = rises[k];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/evdma_wrap_ptr.sv
`timescale 1ns/1ps
module evdma_wrap_ptr #(
    parameter int SIZE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              step,
    input  logic              wide,
    input  logic [SIZE_W-1:0] size,
    output logic [SIZE_W-1:0] off
);
    localparam logic [SIZE_W:0] ONE = (SIZE_W+1)'(1);
    localparam logic [SIZE_W:0] TWO = (SIZE_W+1)'(2);

    logic [SIZE_W-1:0] off_d, off_q;
    logic [SIZE_W:0]   sum;

    always_comb begin
        sum   = {1'b0, off_q} + (wide ? TWO : ONE);
        off_d = off_q;
        if (clr) begin
            off_d = '0;
        end else if (step) begin
            // wrap back to the region start once the size is reached
            off_d = (sum >= {1'b0, size}) ? '0 : sum[SIZE_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) off_q <= '0;
        else        off_q <= off_d;
    end

    assign off = off_q;
endmodule

// File: rtl/evdma_lane.sv
`timescale 1ns/1ps
module evdma_lane
    import evdma_pkg::*;
(
    input  logic              wide,
    input  logic              src_odd,
    input  logic              dst_odd,
    input  logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] wdata,
    output logic [BE_W-1:0]   be,
    output logic [DATA_W-1:0] value
);
    logic [7:0] byte_v;

    always_comb begin
        byte_v = src_odd ? rdata[15:8] : rdata[7:0];
        if (wide) begin
            wdata = rdata;
            be    = 2'b11;
            value = rdata;
        end else begin
            wdata = {byte_v, byte_v};
            be    = dst_odd ? 2'b10 : 2'b01;
            value = {8'h00, byte_v};
        end
    end
endmodule

// File: rtl/evdma_channel.sv
`timescale 1ns/1ps
module evdma_channel
    import evdma_pkg::*;
#(
    parameter int              N_EVT     = 4,
    parameter int              ADDR_W    = 32,
    parameter int              SIZE_W    = 16,
    parameter logic [31:0]     PHYS_MASK = 32'h1FFF_FFFF,
    localparam int             SEL_W     = (N_EVT > 1) ? $clog2(N_EVT) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm,
    input  logic              abort_in,
    input  logic              clear_flags,
    input  logic              cfg_auto,
    input  logic              cfg_wide,
    input  logic              cfg_match_en,
    input  logic [15:0]       cfg_pattern,
    input  logic [SEL_W-1:0]  cfg_evt_sel,
    input  logic [ADDR_W-1:0] cfg_src_base,
    input  logic [ADDR_W-1:0] cfg_dst_base,
    input  logic [SIZE_W-1:0] cfg_src_size,
    input  logic [SIZE_W-1:0] cfg_dst_size,
    input  logic [SIZE_W-1:0] cfg_cell_size,
    input  logic [N_EVT-1:0]  evt_in,
    input  logic [ADDR_W-1:0] virt_addr,
    output logic [ADDR_W-1:0] phys_addr,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [15:0]       rd_data,
    output logic              wr_req,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [15:0]       wr_data,
    output logic [1:0]        wr_be,
    input  logic              mem_ready,
    output logic              armed,
    output logic              done_flag,
    output logic              abort_flag,
    output logic              done_irq,
    output logic              abort_irq
);
    localparam int              PAD_W = ADDR_W - SIZE_W;
    localparam logic [SIZE_W:0] ONE   = (SIZE_W+1)'(1);
    localparam logic [SIZE_W:0] TWO   = (SIZE_W+1)'(2);

    typedef struct packed {
        ch_state_e       st;
        logic            pend;
        logic [SIZE_W:0] cell_cnt;
        logic [SIZE_W:0] blk_cnt;
        logic            done;
        logic            abrt;
        logic            done_irq;
        logic            abrt_irq;
    } regs_t;

    localparam regs_t RESET_VAL = '{
        st: ST_IDLE, pend: 1'b0, cell_cnt: '0, blk_cnt: '0,
        done: 1'b0, abrt: 1'b0, done_irq: 1'b0, abrt_irq: 1'b0
    };

    regs_t r_d, r_q;

    logic              rise;
    logic [SIZE_W-1:0] src_off, dst_off;
    logic [SIZE_W:0]   step_b, blk_len;
    logic [15:0]       moved;
    logic              beat, blk_last, cell_last, hit, blk_end, pend_eff;
    logic              ptr_clr, ptr_step;

    // ---------------- trigger selection ----------------
    evdma_edge #(.N_EVT(N_EVT), .SEL_W(SEL_W)) i_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .evt  (evt_in),
        .sel  (cfg_evt_sel),
        .rise (rise)
    );

    // ---------------- wrapping offsets ----------------
    evdma_wrap_ptr #(.SIZE_W(SIZE_W)) i_src_ptr (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (ptr_clr),
        .step (ptr_step),
        .wide (cfg_wide),
        .size (cfg_src_size),
        .off  (src_off)
    );

    evdma_wrap_ptr #(.SIZE_W(SIZE_W)) i_dst_ptr (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (ptr_clr),
        .step (ptr_step),
        .wide (cfg_wide),
        .size (cfg_dst_size),
        .off  (dst_off)
    );

    // ---------------- address and lane steering ----------------
    assign rd_addr = cfg_src_base + {{PAD_W{1'b0}}, src_off};
    assign wr_addr = cfg_dst_base + {{PAD_W{1'b0}}, dst_off};

    evdma_lane i_lane (
        .wide   (cfg_wide),
        .src_odd(rd_addr[0]),
        .dst_odd(wr_addr[0]),
        .rdata  (rd_data),
        .wdata  (wr_data),
        .be     (wr_be),
        .value  (moved)
    );

    assign phys_addr = virt_addr & PHYS_MASK[ADDR_W-1:0];

    // ---------------- next-state logic ----------------
    always_comb begin
        step_b    = cfg_wide ? TWO : ONE;
        blk_len   = (cfg_src_size >= cfg_dst_size) ? {1'b0, cfg_src_size}
                                                   : {1'b0, cfg_dst_size};
        beat      = (r_q.st == ST_MOVE) && mem_ready;
        blk_last  = (r_q.blk_cnt + step_b) >= blk_len;
        cell_last = (r_q.cell_cnt + step_b) >= {1'b0, cfg_cell_size};
        hit       = cfg_match_en && (moved == cfg_pattern);
        blk_end   = beat && (blk_last || hit);
        pend_eff  = r_q.pend || (rise && (r_q.st == ST_MOVE));

        r_d          = r_q;
        r_d.done_irq = 1'b0;
        r_d.abrt_irq = 1'b0;

        if (clear_flags) begin
            r_d.done = 1'b0;
            r_d.abrt = 1'b0;
        end

        unique case (r_q.st)
            ST_IDLE: begin
                if (arm) begin
                    r_d.st       = ST_ARMED;
                    r_d.done     = 1'b0;
                    r_d.abrt     = 1'b0;
                    r_d.pend     = 1'b0;
                    r_d.cell_cnt = '0;
                    r_d.blk_cnt  = '0;
                end
            end
            ST_ARMED: begin
                if (rise) r_d.st = ST_MOVE;
            end
            ST_MOVE: begin
                r_d.pend = pend_eff;
                if (beat) begin
                    r_d.cell_cnt = r_q.cell_cnt + step_b;
                    r_d.blk_cnt  = r_q.blk_cnt + step_b;
                    if (blk_end) begin
                        r_d.done     = 1'b1;
                        r_d.done_irq = 1'b1;
                        r_d.cell_cnt = '0;
                        r_d.blk_cnt  = '0;
                        r_d.pend     = 1'b0;
                        if (cfg_auto) r_d.st = pend_eff ? ST_MOVE : ST_ARMED;
                        else          r_d.st = ST_IDLE;
                    end else if (cell_last) begin
                        r_d.cell_cnt = '0;
                        r_d.pend     = 1'b0;
                        r_d.st       = pend_eff ? ST_MOVE : ST_ARMED;
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase

        if (abort_in) begin
            r_d.st       = ST_IDLE;
            r_d.pend     = 1'b0;
            r_d.cell_cnt = '0;
            r_d.blk_cnt  = '0;
            r_d.abrt     = 1'b1;
            r_d.abrt_irq = 1'b1;
        end

        ptr_clr  = blk_end || abort_in || ((r_q.st == ST_IDLE) && arm);
        ptr_step = beat && !blk_end;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= RESET_VAL;
        else        r_q <= r_d;
    end

    // ---------------- outputs ----------------
    assign rd_req     = (r_q.st == ST_MOVE);
    assign wr_req     = (r_q.st == ST_MOVE);
    assign armed      = (r_q.st != ST_IDLE);
    assign done_flag  = r_q.done;
    assign abort_flag = r_q.abrt;
    assign done_irq   = r_q.done_irq;
    assign abort_irq  = r_q.abrt_irq;
endmodule

// File: rtl/evdma_channel_chk.sv
`timescale 1ns/1ps
module evdma_channel_chk #(
    parameter int ADDR_W = 32,
    parameter int SIZE_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              abort_in,
    input logic              cfg_auto,
    input logic              cfg_wide,
    input logic [ADDR_W-1:0] cfg_src_base,
    input logic [SIZE_W-1:0] cfg_src_size,
    input logic              mem_ready,
    input logic              rd_req,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              wr_req,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [1:0]        wr_be,
    input logic              armed,
    input logic              done_flag,
    input logic              abort_flag,
    input logic              done_irq
);
    logic [ADDR_W-1:0] src_rel;
    assign src_rel = rd_addr - cfg_src_base;

    // R2: a stalled beat keeps its request and both addresses
    a_r2_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !mem_ready && !abort_in) |=> (rd_req && $stable(rd_addr) && $stable(wr_addr)));

    // R3: reads stay inside the source region
    a_r3_src_in_region: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> (src_rel < {{(ADDR_W-SIZE_W){1'b0}}, cfg_src_size}));

    // R4: completion pulse comes with the sticky flag
    a_r4_irq_with_flag: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq |-> done_flag);

    // R6: one-shot completion disarms
    a_r6_oneshot_disarm: assert property (@(posedge clk) disable iff (!rst_n)
        (done_irq && !cfg_auto) |-> !armed);

    // R7: abort stops the channel and flags it
    a_r7_abort_stops: assert property (@(posedge clk) disable iff (!rst_n)
        abort_in |=> (!armed && abort_flag && !rd_req));

    // R9: byte lanes
    a_r9_narrow_lane: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !cfg_wide) |-> ($countones(wr_be) == 1));

    a_r9_wide_lanes: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && cfg_wide) |-> (wr_be == 2'b11));
endmodule

bind evdma_channel evdma_channel_chk #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .abort_in    (abort_in),
    .cfg_auto    (cfg_auto),
    .cfg_wide    (cfg_wide),
    .cfg_src_base(cfg_src_base),
    .cfg_src_size(cfg_src_size),
    .mem_ready   (mem_ready),
    .rd_req      (rd_req),
    .rd_addr     (rd_addr),
    .wr_req      (wr_req),
    .wr_addr     (wr_addr),
    .wr_be       (wr_be),
    .armed       (armed),
    .done_flag   (done_flag),
    .abort_flag  (abort_flag),
    .done_irq    (done_irq)
);

// File: tb/test_evdma_channel.sv
`timescale 1ns/1ps
module test_evdma_channel;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        arm = 0, abort_in = 0, clear_flags = 0;
    logic        cfg_auto = 0, cfg_wide = 1, cfg_match_en = 0;
    logic [15:0] cfg_pattern = 16'h0;
    logic [1:0]  cfg_evt_sel = 0;
    logic [31:0] cfg_src_base = 0, cfg_dst_base = 0;
    logic [15:0] cfg_src_size = 2, cfg_dst_size = 2, cfg_cell_size = 2;
    logic [3:0]  evt_in = 0;
    logic [31:0] virt_addr = 0, phys_addr;
    logic        rd_req, wr_req, mem_ready = 1;
    logic [31:0] rd_addr, wr_addr;
    logic [15:0] rd_data, wr_data;
    logic [1:0]  wr_be;
    logic        armed, done_flag, abort_flag, done_irq, abort_irq;

    logic [15:0] mem [0:255];
    logic [31:0] log_addr [0:255];
    logic [15:0] log_data [0:255];
    logic [1:0]  log_be   [0:255];
    int wcnt = 0, n_done = 0, n_abort = 0;
    int checks = 0, fails = 0;

    always #2.5 clk = ~clk;

    evdma_channel i_evdma_channel (.*);

    assign rd_data = mem[rd_addr[8:1]];

    always @(negedge clk) begin
        if (rst_n) begin
            if (wr_req && mem_ready) begin
                if (wr_be[0]) mem[wr_addr[8:1]][7:0]  = wr_data[7:0];
                if (wr_be[1]) mem[wr_addr[8:1]][15:8] = wr_data[15:8];
                if (wcnt < 256) begin
                    log_addr[wcnt] = wr_addr;
                    log_data[wcnt] = wr_data;
                    log_be[wcnt]   = wr_be;
                end
                wcnt++;
            end
            if (done_irq)  n_done++;
            if (abort_irq) n_abort++;
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic sample();
        @(negedge clk);
        #1;
    endtask

    task automatic fire(input int i);
        @(posedge clk); #1 evt_in[i] = 1'b1;
        @(posedge clk); #1 evt_in[i] = 1'b0;
    endtask

    task automatic pulse_arm();
        @(posedge clk); #1 arm = 1'b1;
        @(posedge clk); #1 arm = 1'b0;
    endtask

    task automatic pulse_abort();
        @(posedge clk); #1 abort_in = 1'b1;
        @(posedge clk); #1 abort_in = 1'b0;
    endtask

    task automatic pulse_clear();
        @(posedge clk); #1 clear_flags = 1'b1;
        @(posedge clk); #1 clear_flags = 1'b0;
    endtask

    task automatic t_reset();
        sample();
        chk("R12", "armed", {31'b0, armed}, 0);
        chk("R12", "flags", {30'b0, done_flag, abort_flag}, 0);
        chk("R12", "requests", {30'b0, rd_req, wr_req}, 0);
    endtask

    task automatic t_virt();
        virt_addr = 32'hA000_1234; #1;
        chk("R10", "mask low", phys_addr, 32'h0000_1234);
        virt_addr = 32'hFFFF_FFFF; #1;
        chk("R10", "mask all", phys_addr, 32'h1FFF_FFFF);
    endtask

    // fixed register fills an array, one-shot
    task automatic t_fill();
        int w0, d0, bad;
        cfg_wide = 1; cfg_auto = 0; cfg_evt_sel = 1;
        cfg_src_base = 32'h40; cfg_src_size = 2;
        cfg_dst_base = 32'h80; cfg_dst_size = 16; cfg_cell_size = 2;
        for (int k = 0; k < 8; k++) mem[8'h40 + k] = 16'h0;
        pulse_arm();
        w0 = wcnt; d0 = n_done;
        fire(0); fire(2); idle(3); sample();
        chk("R1", "unselected lines move nothing", wcnt - w0, 0);
        for (int k = 0; k < 8; k++) begin
            mem[8'h20] = 16'h0100 + 16'(k);
            fire(1);
            idle(3);
        end
        sample();
        bad = 0;
        for (int k = 0; k < 8; k++) if (mem[8'h40 + k] !== 16'h0100 + 16'(k)) bad++;
        chk("R3", "fixed source fills array", bad, 0);
        chk("R2", "one beat per event", wcnt - w0, 8);
        chk("R4", "done flag", {31'b0, done_flag}, 1);
        chk("R4", "done pulses", n_done - d0, 1);
        chk("R6", "one-shot disarms", {31'b0, armed}, 0);
        mem[8'h20] = 16'hDEAD; w0 = wcnt;
        fire(1); idle(3); sample();
        chk("R6", "trigger after one-shot", wcnt - w0, 0);
        chk("R6", "array untouched", {16'b0, mem[8'h40]}, 32'h0100);
    endtask

    // table replay into one register, repeat mode
    task automatic t_replay();
        int d0;
        logic [15:0] got [0:5];
        cfg_wide = 1; cfg_auto = 1; cfg_evt_sel = 2;
        cfg_src_base = 32'h20; cfg_src_size = 8;
        cfg_dst_base = 32'h60; cfg_dst_size = 2; cfg_cell_size = 2;
        for (int k = 0; k < 4; k++) mem[8'h10 + k] = 16'hA000 + 16'(k);
        pulse_arm();
        sample();
        chk("R11", "arm clears done", {31'b0, done_flag}, 0);
        d0 = n_done;
        for (int k = 0; k < 6; k++) begin
            fire(2); idle(3); sample();
            got[k] = mem[8'h30];
        end
        for (int k = 0; k < 6; k++)
            chk("R6", "replayed table entry", {16'b0, got[k]}, 32'hA000 + 32'(k % 4));
        chk("R4", "one block done", n_done - d0, 1);
        chk("R6", "repeat stays armed", {31'b0, armed}, 1);
        pulse_abort();
    endtask

    // stall and pending trigger
    task automatic t_pending();
        int w0, bad;
        cfg_wide = 1; cfg_auto = 0; cfg_evt_sel = 0;
        cfg_src_base = 32'h00; cfg_src_size = 12;
        cfg_dst_base = 32'hA0; cfg_dst_size = 12; cfg_cell_size = 6;
        for (int k = 0; k < 6; k++) begin
            mem[k] = 16'hB000 + 16'(k);
            mem[8'h50 + k] = 16'h0;
        end
        pulse_arm();
        @(posedge clk); #1 mem_ready = 1'b0;
        w0 = wcnt;
        fire(0);
        fire(0);
        idle(3); sample();
        chk("R2", "no beat while not ready", wcnt - w0, 0);
        chk("R2", "request held", {31'b0, rd_req}, 1);
        @(posedge clk); #1 mem_ready = 1'b1;
        idle(10); sample();
        chk("R8", "pending trigger served", wcnt - w0, 6);
        bad = 0;
        for (int k = 0; k < 6; k++) if (mem[8'h50 + k] !== 16'hB000 + 16'(k)) bad++;
        chk("R8", "both cells copied", bad, 0);
        chk("R4", "done after two cells", {31'b0, done_flag}, 1);
    endtask

    // byte beats with an odd destination
    task automatic t_narrow();
        int w0;
        cfg_wide = 0; cfg_auto = 0; cfg_evt_sel = 3;
        cfg_src_base = 32'hE0; cfg_src_size = 4;
        cfg_dst_base = 32'hF1; cfg_dst_size = 4; cfg_cell_size = 2;
        mem[8'h70] = 16'h2211; mem[8'h71] = 16'h4433;
        mem[8'h78] = 16'hEEEE; mem[8'h79] = 16'hEEEE; mem[8'h7A] = 16'hEEEE;
        pulse_arm();
        w0 = wcnt;
        fire(3); idle(4); sample();
        chk("R2", "two byte beats per cell", wcnt - w0, 2);
        chk("R9", "high lane enable", {30'b0, log_be[w0]}, 2'b10);
        chk("R9", "byte replicated", {16'b0, log_data[w0]}, 32'h1111);
        chk("R9", "odd byte placed", {16'b0, mem[8'h78]}, 32'h11EE);
        chk("R9", "even byte placed", {16'b0, mem[8'h79]}, 32'hEE22);
        fire(3); idle(4); sample();
        chk("R9", "second cell high", {16'b0, mem[8'h79]}, 32'h3322);
        chk("R3", "destination end", {16'b0, mem[8'h7A]}, 32'hEE44);
        chk("R4", "narrow block done", {31'b0, done_flag}, 1);
        cfg_wide = 1;
    endtask

    // pattern stop
    task automatic t_match();
        int w0;
        cfg_wide = 1; cfg_auto = 0; cfg_evt_sel = 1;
        cfg_match_en = 1; cfg_pattern = 16'h5A5A;
        cfg_src_base = 32'h00; cfg_src_size = 16;
        cfg_dst_base = 32'hC0; cfg_dst_size = 16; cfg_cell_size = 16;
        for (int k = 0; k < 8; k++) begin
            mem[k] = 16'hC000 + 16'(k);
            mem[8'h60 + k] = 16'h0;
        end
        mem[2] = 16'h5A5A;
        pulse_arm();
        w0 = wcnt;
        fire(1); idle(12); sample();
        chk("R5", "stops after match", wcnt - w0, 3);
        chk("R5", "matched value written", {16'b0, mem[8'h62]}, 32'h5A5A);
        chk("R5", "next slot untouched", {16'b0, mem[8'h63]}, 0);
        chk("R5", "done on match", {31'b0, done_flag}, 1);
        pulse_clear(); sample();
        chk("R11", "clear drops done", {31'b0, done_flag}, 0);
        cfg_match_en = 0;
    endtask

    // abort and restart from base
    task automatic t_abort();
        int w0, a0;
        cfg_wide = 1; cfg_auto = 0; cfg_evt_sel = 3;
        cfg_src_base = 32'h00; cfg_src_size = 16;
        cfg_dst_base = 32'hC0; cfg_dst_size = 16; cfg_cell_size = 4;
        for (int k = 0; k < 8; k++) mem[k] = 16'hD000 + 16'(k);
        pulse_arm();
        w0 = wcnt; a0 = n_abort;
        fire(3); idle(4); sample();
        chk("R2", "two-beat cell", wcnt - w0, 2);
        pulse_abort(); sample();
        chk("R7", "disarmed", {31'b0, armed}, 0);
        chk("R7", "abort flag", {31'b0, abort_flag}, 1);
        chk("R7", "abort pulse", n_abort - a0, 1);
        w0 = wcnt;
        fire(3); idle(3); sample();
        chk("R7", "trigger after abort", wcnt - w0, 0);
        pulse_arm(); sample();
        chk("R11", "arm clears abort", {31'b0, abort_flag}, 0);
        w0 = wcnt;
        fire(3); idle(4); sample();
        chk("R7", "restart dst base", log_addr[w0], 32'hC0);
        chk("R7", "restart src base", {16'b0, log_data[w0]}, 32'hD000);
        pulse_abort();
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL R12 watchdog actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        for (int k = 0; k < 256; k++) mem[k] = 16'h0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_virt();
        t_fill();
        t_replay();
        t_pending();
        t_narrow();
        t_match();
        t_abort();
        idle(2);
        summary();
        $finish;
    end
endmodule